// File: doc/BRIEF.md
# SPI register frame decoder

This block is the slave end of a serial register port for a modem. A host drives SPI mode 1 (clock idles low, the slave samples on the falling edge and changes its output on the rising edge) with the most significant bit first. Every transaction is a fixed frame: an 8-bit command followed by a 16-bit data word, with chip select held low for the whole frame. An optional CRC-8 byte can be appended; a configuration bit decides whether it is required.

The four SPI pins are oversampled in the core clock domain. The frame is checked when chip select rises. A valid write produces a single-cycle commit pulse carrying the address and data, updates the local configuration or scratch register, and for the transmit-queue address pushes exactly one parity-plus-data word. A read is split over two frames. The first frame names the register. The value is returned during the following frame, and an all-zero frame is enough to fetch it. The serial output stays high-impedance until software clears the output-disable bit.

Top module: `spi_reg_decoder`

## Requirements
- R1: Frames are sampled in SPI mode 1, MSB first. Command bit 7 set means read, and command bits 6:0 are the register address. The 16 bits after the command are the data.
- R2: A valid write frame to a nonzero address raises `commit_o` for exactly one core cycle after chip select rises, with `commit_addr_o` and `commit_data_o` equal to the frame's address and data. Address 0 (the all-zero frame) commits nothing.
- R3: A valid write to address 0x15 raises `fifo_push_o` once, in the same cycle as its commit. `fifo_word_o` carries the 16 data bits: the upper byte is the parity byte and the lower byte is the data byte. Bits beyond the frame never produce a second push.
- R4: After a valid read frame, the next frame shifts out the read command byte followed by the 16-bit register value, MSB first. Each bit appears after a rising SCLK edge, and zeros follow. The configuration and scratch registers return their value, and any other address returns 0.
- R5: `miso_oe_o` is low while configuration bit 0 (output disable) is 1 and whenever chip select is high.
- R6: With the CRC off, a frame is accepted only if exactly 24 bits were clocked. With the CRC on, it is accepted only if exactly 32 bits were clocked. Any other frame is dropped.
- R7: With the CRC on, the last byte must equal the CRC-8 (polynomial 0x07, initial value 0, MSB first, no reflection) of the 24 frame bits. Otherwise the frame is dropped.
- R8: The configuration register is at 0x02. Bit 0 is output disable and bit 1 is CRC enable, and the register resets to 0x0001. The scratch register is at 0x03 and resets to 0.
- R9: A dropped frame changes no register, raises no strobe and leaves the pending read value in place for the next frame.
- R10: Out of reset, `miso_oe_o`, `commit_o` and `fifo_push_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, much faster than SCLK |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from host |
| cs_ni | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| miso_oe_o | output | 1 | Output enable for the MISO pad; low means high-impedance |
| commit_o | output | 1 | One-cycle strobe for an accepted write |
| commit_addr_o | output | 7 | Address of the accepted write |
| commit_data_o | output | 16 | Data of the accepted write |
| fifo_push_o | output | 1 | One-cycle push into the transmit queue |
| fifo_word_o | output | 16 | Parity byte (upper) and data byte (lower) pushed |

## Verification
The hardest case to reach is a read value that survives a dropped frame. To get there, the stimulus issues a read, then a frame of the wrong length or with a corrupted CRC byte, then a zero frame, and checks that the same value is shifted out twice. Switching the CRC requirement on at run time is also awkward. The write that enables it must still use the 24-bit format. Every later frame must then carry a correctly computed CRC byte, and 24-bit frames and frames with a bad CRC byte must have no effect. The reference model predicts the strobes and the serial output of every frame from its own copy of the register state.

// File: rtl/spi_dec_pkg.sv
package spi_dec_pkg;
  localparam int CMD_W     = 8;
  localparam int DAT_W     = 16;
  localparam int CRC_W     = 8;
  localparam int ADDR_W    = CMD_W - 1;
  localparam int FRM_W     = CMD_W + DAT_W;
  localparam int FRM_CRC_W = FRM_W + CRC_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DAT_W-1:0]  data_t;

  typedef struct packed {
    logic  rd;
    addr_t addr;
    data_t data;
  } frame_t;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] crc,
                                                input logic din,
                                                input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] sh;
    sh = {crc[CRC_W-2:0], 1'b0};
    return (crc[CRC_W-1] ^ din) ? (sh ^ poly) : sh;
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_rx.sv
module spi_rx
  import spi_dec_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 8'h07
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cs_act_i,
  input  logic   cs_fall_i,
  input  logic   cs_rise_i,
  input  logic   sclk_fall_i,
  input  logic   mosi_i,
  input  logic   crc_en_i,
  output logic   frm_vld_o,
  output frame_t frm_o
);
  localparam int CNT_W = $clog2(FRM_CRC_W + 2);
  localparam logic [CNT_W-1:0] LEN_PLAIN = CNT_W'(FRM_W);
  localparam logic [CNT_W-1:0] LEN_CRC   = CNT_W'(FRM_CRC_W);

  logic [FRM_CRC_W-1:0] sr_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [CRC_W-1:0]     crc_q;
  logic                 len_ok, crc_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
      crc_q <= '0;
    end else if (cs_fall_i) begin
      cnt_q <= '0;
      crc_q <= '0;
    end else if (cs_act_i && sclk_fall_i) begin
      sr_q <= {sr_q[FRM_CRC_W-2:0], mosi_i};
      if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      // running CRC covers the command and data bits only
      if (cnt_q < LEN_PLAIN) crc_q <= crc_step(crc_q, mosi_i, POLY);
    end
  end

  assign len_ok = crc_en_i ? (cnt_q == LEN_CRC) : (cnt_q == LEN_PLAIN);
  assign crc_ok = !crc_en_i || (sr_q[CRC_W-1:0] == crc_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frm_vld_o <= 1'b0;
      frm_o     <= '0;
    end else begin
      frm_vld_o <= cs_rise_i && len_ok && crc_ok;
      if (cs_rise_i)
        frm_o <= frame_t'(crc_en_i ? sr_q[FRM_CRC_W-1:CRC_W] : sr_q[FRM_W-1:0]);
    end
  end
endmodule

// File: rtl/spi_tx.sv
module spi_tx
  import spi_dec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_act_i,
  input  logic             cs_fall_i,
  input  logic             sclk_rise_i,
  input  logic [FRM_W-1:0] load_i,
  output logic             bit_o
);
  logic [FRM_W-1:0] sr_q;
  logic             first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      first_q <= 1'b0;
    end else if (cs_fall_i) begin
      sr_q    <= load_i;
      first_q <= 1'b1;
    end else if (cs_act_i && sclk_rise_i) begin
      // first rising edge presents the MSB already loaded
      if (first_q) first_q <= 1'b0;
      else         sr_q    <= {sr_q[FRM_W-2:0], 1'b0};
    end
  end

  assign bit_o = sr_q[FRM_W-1];
endmodule

// File: rtl/spi_reg_decoder.sv
module spi_reg_decoder
  import spi_dec_pkg::*;
#(
  parameter logic [CRC_W-1:0]  POLY        = 8'h07,
  parameter logic [ADDR_W-1:0] CFG_ADDR    = 7'h02,
  parameter logic [ADDR_W-1:0] SCR_ADDR    = 7'h03,
  parameter logic [ADDR_W-1:0] FIFO_ADDR   = 7'h15,
  parameter logic [DAT_W-1:0]  CFG_RST     = 16'h0001,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              commit_o,
  output logic [ADDR_W-1:0] commit_addr_o,
  output logic [DAT_W-1:0]  commit_data_o,
  output logic              fifo_push_o,
  output logic [DAT_W-1:0]  fifo_word_o
);
  localparam int SDO_DIS_BIT = 0;
  localparam int CRC_EN_BIT  = 1;

  logic [2:0] pin_s;
  logic       sclk_d_q, cs_d_q;
  logic       sclk_rise, sclk_fall, cs_rise, cs_fall, cs_act;
  logic       frm_vld;
  frame_t     frm;
  logic [DAT_W-1:0] cfg_q, scr_q, rd_val;
  logic [FRM_W-1:0] rd_buf_q;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, cs_ni, mosi_i}),
    .q_o   (pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      cs_d_q   <= 1'b1;
    end else begin
      sclk_d_q <= pin_s[2];
      cs_d_q   <= pin_s[1];
    end
  end

  assign sclk_rise = pin_s[2] & ~sclk_d_q;
  assign sclk_fall = ~pin_s[2] & sclk_d_q;
  assign cs_rise   = pin_s[1] & ~cs_d_q;
  assign cs_fall   = ~pin_s[1] & cs_d_q;
  assign cs_act    = ~pin_s[1];

  spi_rx #(.POLY(POLY)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_act_i   (cs_act),
    .cs_fall_i  (cs_fall),
    .cs_rise_i  (cs_rise),
    .sclk_fall_i(sclk_fall),
    .mosi_i     (pin_s[0]),
    .crc_en_i   (cfg_q[CRC_EN_BIT]),
    .frm_vld_o  (frm_vld),
    .frm_o      (frm)
  );

  spi_tx u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_act_i   (cs_act),
    .cs_fall_i  (cs_fall),
    .sclk_rise_i(sclk_rise),
    .load_i     (rd_buf_q),
    .bit_o      (miso_o)
  );

  always_comb begin
    if (frm.addr == CFG_ADDR)      rd_val = cfg_q;
    else if (frm.addr == SCR_ADDR) rd_val = scr_q;
    else                           rd_val = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q         <= CFG_RST;
      scr_q         <= '0;
      rd_buf_q      <= '0;
      commit_o      <= 1'b0;
      commit_addr_o <= '0;
      commit_data_o <= '0;
      fifo_push_o   <= 1'b0;
      fifo_word_o   <= '0;
    end else begin
      commit_o    <= 1'b0;
      fifo_push_o <= 1'b0;
      if (frm_vld) begin
        if (frm.rd) begin
          rd_buf_q <= {1'b1, frm.addr, rd_val};
        end else begin
          rd_buf_q <= '0;
          if (frm.addr != '0) begin
            commit_o      <= 1'b1;
            commit_addr_o <= frm.addr;
            commit_data_o <= frm.data;
          end
          if (frm.addr == CFG_ADDR) cfg_q <= frm.data;
          if (frm.addr == SCR_ADDR) scr_q <= frm.data;
          if (frm.addr == FIFO_ADDR) begin
            fifo_push_o <= 1'b1;
            fifo_word_o <= frm.data;
          end
        end
      end
    end
  end

  assign miso_oe_o = cs_act & ~cfg_q[SDO_DIS_BIT];
endmodule

// File: rtl/spi_reg_decoder_chk.sv
module spi_reg_decoder_chk #(
  parameter logic [6:0] CFG_ADDR  = 7'h02,
  parameter logic [6:0] FIFO_ADDR = 7'h15
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cs_ni,
  input logic        miso_oe_o,
  input logic        commit_o,
  input logic [6:0]  commit_addr_o,
  input logic [15:0] commit_data_o,
  input logic        fifo_push_o,
  input logic [15:0] fifo_word_o,
  input logic [15:0] cfg_i
);
  assert_single_commit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);

  assert_commit_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> commit_addr_o != 7'd0);

  assert_push_matches_commit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_push_o |-> (commit_o && commit_addr_o == FIFO_ADDR && fifo_word_o == commit_data_o));

  assert_oe_disabled_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i[0] |-> !miso_oe_o);

  assert_oe_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2)) |-> !miso_oe_o);

  assert_cfg_by_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i != $past(cfg_i)) |-> (commit_o && commit_addr_o == CFG_ADDR));
endmodule

bind spi_reg_decoder spi_reg_decoder_chk #(.CFG_ADDR(CFG_ADDR), .FIFO_ADDR(FIFO_ADDR)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_ni        (cs_ni),
  .miso_oe_o    (miso_oe_o),
  .commit_o     (commit_o),
  .commit_addr_o(commit_addr_o),
  .commit_data_o(commit_data_o),
  .fifo_push_o  (fifo_push_o),
  .fifo_word_o  (fifo_word_o),
  .cfg_i        (cfg_q)
);

// File: tb/tb_spi_reg_decoder.sv
module tb_spi_reg_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam logic [7:0] POLY = 8'h07;

  logic clk = 1'b0;
  logic rst_ni, sclk, cs_n, mosi;
  logic miso_o, miso_oe_o, commit_o, fifo_push_o;
  logic [6:0]  commit_addr_o;
  logic [15:0] commit_data_o, fifo_word_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_reg_decoder dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o),
    .commit_o(commit_o), .commit_addr_o(commit_addr_o), .commit_data_o(commit_data_o),
    .fifo_push_o(fifo_push_o), .fifo_word_o(fifo_word_o)
  );

  int n_cmp = 0, n_bad = 0;
  int seen_commit = 0, seen_push = 0, exp_commit = 0, exp_push = 0;
  bit done = 0;
  logic [22:0] commit_q[$];
  logic [15:0] push_q[$];

  // reference state
  logic [15:0] m_cfg = 16'h0001;
  logic [15:0] m_scr = 16'h0000;
  logic [23:0] m_rdbuf = 24'h0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crc8(input logic [23:0] f);
    logic [7:0] c = 8'h00;
    for (int i = 23; i >= 0; i--)
      c = (c[7] ^ f[i]) ? ({c[6:0], 1'b0} ^ POLY) : {c[6:0], 1'b0};
    return c;
  endfunction

  function automatic logic [15:0] fifo_word(input logic [7:0] b);
    return {7'h0, ~^b, b};
  endfunction

  always @(negedge clk) if (rst_ni) begin
    if (commit_o) begin
      seen_commit++;
      if (commit_q.size() == 0) chk(0, "R2 unexpected commit", {9'h0, commit_addr_o, commit_data_o}, 0);
      else begin
        logic [22:0] e;
        e = commit_q.pop_front();
        chk({commit_addr_o, commit_data_o} == e, "R2 commit addr/data", {9'h0, commit_addr_o, commit_data_o}, {9'h0, e});
      end
    end
    if (fifo_push_o) begin
      seen_push++;
      if (push_q.size() == 0) chk(0, "R3 unexpected push", {16'h0, fifo_word_o}, 0);
      else begin
        logic [15:0] e;
        e = push_q.pop_front();
        chk(fifo_word_o == e, "R3 push word", {16'h0, fifo_word_o}, {16'h0, e});
      end
    end
  end

  task automatic spi_xfer(input logic [31:0] word, input int nbits, output logic [31:0] got,
                          output int oe_hi, output int oe_lo);
    got = 0; oe_hi = 0; oe_lo = 0;
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = nbits - 1; i >= 0; i--) begin
      sclk = 1'b1; mosi = word[i];
      repeat (HALF) @(negedge clk);
      got = {got[30:0], miso_o};
      if (miso_oe_o) oe_hi++; else oe_lo++;
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    cs_n = 1'b1; mosi = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  // nbits: 24 plain, 32 adds CRC byte, other counts are malformed
  task automatic do_frame(input logic [23:0] f, input int nbits, input bit bad_crc, input string req);
    logic [31:0] word, got, exp_out;
    int oe_hi, oe_lo;
    bit valid, exp_oe;
    if (nbits == 32) word = {f, crc8(f) ^ (bad_crc ? 8'h01 : 8'h00)};
    else             word = {8'h0, f} >> (24 - nbits);
    valid   = m_cfg[1] ? (nbits == 32 && !bad_crc) : (nbits == 24);
    exp_oe  = !m_cfg[0];
    exp_out = {m_rdbuf, 8'h00} >> (32 - nbits);
    if (valid && !f[23]) begin
      if (f[22:16] != 7'h0) begin commit_q.push_back(f[22:0]); exp_commit++; end
      if (f[22:16] == 7'h15) begin push_q.push_back(f[15:0]); exp_push++; end
    end
    spi_xfer(word, nbits, got, oe_hi, oe_lo);
    if (exp_oe) begin
      chk(oe_lo == 0, {req, " R5 oe during frame"}, oe_lo, 0);
      chk(got == exp_out, {req, " R4 R1 readback bits"}, got, exp_out);
    end else begin
      chk(oe_hi == 0, {req, " R5 oe must stay low"}, oe_hi, 0);
    end
    chk(seen_commit == exp_commit, {req, " R2 R9 commit count"}, seen_commit, exp_commit);
    chk(seen_push == exp_push, {req, " R3 R9 push count"}, seen_push, exp_push);
    if (valid) begin
      if (f[23]) begin
        case (f[22:16])
          7'h02:   m_rdbuf = {f[23:16], m_cfg};
          7'h03:   m_rdbuf = {f[23:16], m_scr};
          default: m_rdbuf = {f[23:16], 16'h0};
        endcase
      end else begin
        m_rdbuf = 24'h0;
        if (f[22:16] == 7'h02) m_cfg = f[15:0];
        if (f[22:16] == 7'h03) m_scr = f[15:0];
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
    repeat (5) @(negedge clk);
    chk(miso_oe_o == 0, "R10 reset oe", miso_oe_o, 0);
    chk(commit_o == 0, "R10 reset commit", commit_o, 0);
    chk(fifo_push_o == 0, "R10 reset push", fifo_push_o, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    // R8 reset defaults: output disabled, so readback stays hidden (R5)
    do_frame(24'h830000, 24, 0, "R8 read scratch oe off");
    do_frame(24'h000000, 24, 0, "R5 nop oe off");
    do_frame(24'h020000, 24, 0, "R8 enable output");
    do_frame(24'h03BEEF, 24, 0, "R2 write scratch");
    do_frame(24'h830000, 24, 0, "R1 read scratch");
    do_frame(24'h820000, 24, 0, "R4 read cfg");
    do_frame(24'h950000, 24, 0, "R4 read fifo addr");
    do_frame(24'h000000, 24, 0, "R4 nop fetch");
    // R3 one push per frame, parity byte is odd-parity bit
    do_frame({8'h15, fifo_word(8'hFF)}, 24, 0, "R3 push ff");
    do_frame({8'h15, fifo_word(8'h00)}, 24, 0, "R3 push 00");
    do_frame({8'h15, fifo_word(8'h01)}, 24, 0, "R3 push 01");
    do_frame({8'h15, fifo_word(8'hA5)}, 24, 0, "R3 push a5");
    // R6 wrong lengths dropped
    do_frame(24'h151234, 16, 0, "R6 short frame");
    do_frame(24'h035555, 32, 0, "R6 long frame crc off");
    do_frame(24'h150101, 25, 0, "R6 extra bit fifo");
    // R9 pending read survives a dropped frame
    do_frame(24'h830000, 24, 0, "R9 read scratch");
    do_frame(24'h03AAAA, 20, 0, "R9 dropped frame");
    do_frame(24'h000000, 24, 0, "R9 nop after drop");
    // R7 enable CRC
    do_frame(24'h020002, 24, 0, "R7 enable crc");
    do_frame(24'h031234, 32, 0, "R7 crc write ok");
    do_frame(24'h035555, 32, 1, "R7 bad crc");
    do_frame(24'h036666, 24, 0, "R6 24 bits with crc on");
    do_frame(24'h830000, 32, 0, "R7 read scratch crc");
    do_frame(24'h000000, 32, 0, "R7 nop crc");
    do_frame({8'h15, fifo_word(8'h3C)}, 32, 0, "R3 push with crc");
    do_frame({8'h15, fifo_word(8'h3D)}, 32, 1, "R7 push bad crc");
    do_frame(24'h820000, 32, 0, "R8 read cfg crc");
    do_frame(24'h020001, 32, 0, "R5 disable output");
    do_frame(24'h830000, 24, 0, "R5 read after disable");
    do_frame(24'h000000, 24, 0, "R5 nop after disable");

    repeat (20) @(negedge clk);
    chk(commit_q.size() == 0, "R2 pending commits", commit_q.size(), 0);
    chk(push_q.size() == 0, "R3 pending pushes", push_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule